// File: doc/BRIEF.md
# Upset-Test Shift Register with Run-Time Triple Redundancy

This block is a test vehicle for measuring how single stored-bit upsets show up at a design's output. A known repeating bit pattern is shifted through a chain of flip-flops. The chain exists in three copies. A control input picks the output source. With redundancy off, the output is the tail of copy 0. With redundancy on, the output is the bitwise majority of the three tails.

A built-in checker regenerates the expected pattern from the same phase counter that feeds the chain. It shifts that pattern by the chain length in arithmetic and compares the result with the output on every cycle. Any difference sets a sticky failure flag and advances a saturating failure counter. An injection port lets a test environment invert one chosen stored bit in one chosen copy. The same upset can then be replayed with and without redundancy and the outcomes compared.

When the redundancy setting changes, copies 1 and 2 are reloaded from copy 0 so that all three copies agree. The checker then ignores the output for one chain length, as it also does after reset.

Top module: `tsr_top`

## Requirements
- R1: Reset is synchronous and active-high. While it is applied and on the cycle after it, `data_out`, `fail_flag` and `fail_count` are all zero. Every copy of the chain holds zeros.
- R2: The pattern is 1101, sent most significant bit first and repeated. Let j be the number of clock edges since reset was released. For j ≥ CHAIN_LEN, `data_out` after edge j equals bit (3 − ((j − CHAIN_LEN) mod 4)) of 4'b1101. For j < CHAIN_LEN it is 0.
- R3: With `tmr_en` low, `data_out` is the tail of copy 0. An upset injected into copy 1 or copy 2 never changes `data_out` and never counts as a failure.
- R4: With `tmr_en` high, `data_out` is the bitwise majority of the three tails. One upset in any single copy is masked. Two upsets in different copies that reach the tail in the same cycle produce a failure.
- R5: An injection fires when `inj_stb` is high at a clock edge. At that edge it inverts the value loaded into position `inj_pos` of copy `inj_copy`. Position 0 is the input end and CHAIN_LEN−1 is the tail. Copy indices 0 to 2 are valid. Index 3 is ignored. The inverted bit appears on `data_out` after CHAIN_LEN−1−`inj_pos` further edges, when that copy drives the output.
- R6: Once the mask period has ended, each cycle in which `data_out` differs from the R2 value raises `fail_count` by exactly one at the next edge and sets `fail_flag`.
- R7: `fail_flag` stays set until reset. `fail_count` saturates at 2^CNT_W − 1, which is 255 by default. It never decreases and rises by at most one per cycle.
- R8: `tmr_en` is registered on every edge. At an edge where it differs from the registered mode, copies 1 and 2 load copy 0's next value. The checker then ignores the output for CHAIN_LEN cycles. A mismatch inside that window is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_en | input | 1 | 1 selects the majority of three copies, 0 selects copy 0 alone |
| inj_stb | input | 1 | Upset injection strobe, one bit flip per cycle in which it is high |
| inj_copy | input | 2 | Copy to upset (0 to 2; 3 is ignored) |
| inj_pos | input | $clog2(CHAIN_LEN) | Stored bit to upset, 0 at the input end |
| data_out | output | 1 | Chain output (tail or voted tail) |
| fail_flag | output | 1 | Sticky functional-failure flag |
| fail_count | output | CNT_W | Saturating count of mismatched output cycles |

## Verification
The bench times a single upset to the exact cycle it reaches the output and the exact cycle the counter moves. A design with an off-by-one in the injection position or in the checker delay would flag the wrong cycle or report false failures on clean data. It replays the same upsets with redundancy off and on, including copies that do not drive the output and the unused copy index. A voter that passes a single bad copy, or a mux that reads the wrong copy, therefore shows up as a counter change. Two aligned upsets in different copies must defeat the voter. An upset made on the same edge as a mode switch must be visible on the output but not counted, which exposes a missing mask. A long run of forced mismatches must stop the counter at its maximum rather than let it wrap.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    // Number of redundant copies of the chain
    localparam int NCOPY = 3;
    // Width of the copy selector on the injection port
    localparam int COPY_W = 2;

    // Output source selection
    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_TRIPLE = 1'b1
    } mode_e;

    // Per-copy tail bits gathered for voting
    typedef struct packed {
        logic t2;
        logic t1;
        logic t0;
    } tails_t;

    // Bitwise two-of-three majority
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Pattern index that was current OFF cycles before the given phase
    function automatic int back_phase(input int ph, input int off, input int plen);
        return (ph + plen - (off % plen)) % plen;
    endfunction

endpackage

// File: rtl/tsr_pattern_src.sv
module tsr_pattern_src
    import tsr_pkg::*;
#(
    parameter int                    PAT_LEN  = 4,
    parameter logic [PAT_LEN-1:0]    PAT_BITS = 4'b1101,
    localparam int                   PH_W     = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output logic            pat_bit
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PAT_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (phase == PH_LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Most significant pattern bit is emitted first
    always_comb begin
        pat_bit = PAT_BITS[PAT_LEN - 1 - int'(phase)];
    end

    // R2: phase never leaves its range
    a_r2_phase_range: assert property (@(posedge clk) disable iff (rst)
        int'(phase) < PAT_LEN);

    // R2: phase advances by one (mod length) every cycle
    a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_LAST) |=> (phase == $past(phase) + 1'b1));

endmodule

// File: rtl/tsr_chain.sv
module tsr_chain #(
    parameter int LEN = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           din,
    input  logic           resync,
    input  logic [LEN-1:0] load,
    input  logic [LEN-1:0] flip,
    output logic [LEN-1:0] q
);

    logic [LEN-1:0] shifted;

    // Position 0 takes the new bit; a set flip bit inverts what lands there
    assign shifted = {q[LEN-2:0], din} ^ flip;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (resync) begin
            q <= load;
        end else begin
            q <= shifted;
        end
    end

    // R1: reset empties the chain
    a_r1_chain_clear: assert property (@(posedge clk)
        rst |=> (q == '0));

endmodule

// File: rtl/tsr_voter.sv
module tsr_voter
    import tsr_pkg::*;
(
    input  tails_t tails,
    input  mode_e  mode,
    output logic   y
);

    logic voted;

    always_comb begin
        voted = maj3(tails.t0, tails.t1, tails.t2);
        unique case (mode)
            MODE_TRIPLE: y = voted;
            default:     y = tails.t0;
        endcase
    end

endmodule

// File: rtl/tsr_checker.sv
module tsr_checker
    import tsr_pkg::*;
#(
    parameter int                    CHAIN_LEN = 32,
    parameter int                    PAT_LEN   = 4,
    parameter logic [PAT_LEN-1:0]    PAT_BITS  = 4'b1101,
    parameter int                    CNT_W     = 8,
    localparam int                   PH_W      = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1,
    localparam int                   MASK_W    = $clog2(CHAIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PH_W-1:0]  phase,
    input  logic             observed,
    input  logic             mode_chg,
    output logic             fail_flag,
    output logic [CNT_W-1:0] fail_count
);

    localparam logic [MASK_W-1:0] MASK_FULL = MASK_W'(CHAIN_LEN);
    localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};

    logic [MASK_W-1:0] mask_cnt;
    logic              expected;
    logic              armed;
    logic              mismatch;

    // The tail now holds the pattern bit from CHAIN_LEN cycles ago
    always_comb begin
        expected = PAT_BITS[PAT_LEN - 1 - back_phase(int'(phase), CHAIN_LEN, PAT_LEN)];
    end

    assign armed    = (mask_cnt == '0);
    assign mismatch = armed && (observed != expected);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_cnt <= MASK_FULL;
        end else if (mode_chg) begin
            mask_cnt <= MASK_FULL;
        end else if (!armed) begin
            mask_cnt <= mask_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_flag  <= 1'b0;
            fail_count <= '0;
        end else if (mismatch) begin
            fail_flag <= 1'b1;
            if (fail_count != CNT_MAX) begin
                fail_count <= fail_count + 1'b1;
            end
        end
    end

    // R7: flag is sticky
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        fail_flag |=> fail_flag);

    // R7: counter never falls and never jumps by more than one
    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fail_count == $past(fail_count)) ||
                  (fail_count == $past(fail_count) + 1'b1)));

    // R7: counter holds once at its ceiling
    a_r7_count_sat: assert property (@(posedge clk) disable iff (rst)
        (fail_count == CNT_MAX) |=> (fail_count == CNT_MAX));

    // R8: no failure is counted while the mask window is open
    a_r8_mask_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask_cnt != '0) |=> $stable(fail_count));

    // R6: a counted failure always leaves the flag set
    a_r6_count_implies_flag: assert property (@(posedge clk) disable iff (rst)
        (fail_count != '0) |-> fail_flag);

endmodule

// File: rtl/tsr_top.sv
module tsr_top
    import tsr_pkg::*;
#(
    parameter int                    CHAIN_LEN = 32,
    parameter int                    PAT_LEN   = 4,
    parameter logic [PAT_LEN-1:0]    PAT_BITS  = 4'b1101,
    parameter int                    CNT_W     = 8,
    localparam int                   POS_W     = $clog2(CHAIN_LEN),
    localparam int                   PH_W      = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tmr_en,
    input  logic                inj_stb,
    input  logic [COPY_W-1:0]   inj_copy,
    input  logic [POS_W-1:0]    inj_pos,
    output logic                data_out,
    output logic                fail_flag,
    output logic [CNT_W-1:0]    fail_count
);

    localparam logic [CHAIN_LEN-1:0] ONE_BIT = {{(CHAIN_LEN-1){1'b0}}, 1'b1};

    logic [PH_W-1:0]      phase;
    logic                 pat_bit;
    mode_e                mode_q;
    logic                 mode_chg;
    logic [CHAIN_LEN-1:0] q    [NCOPY];
    logic [CHAIN_LEN-1:0] flip [NCOPY];
    logic [CHAIN_LEN-1:0] lead_next;
    tails_t               tails;

    // Pattern source shared by all copies
    tsr_pattern_src #(
        .PAT_LEN  (PAT_LEN),
        .PAT_BITS (PAT_BITS)
    ) u_src (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .pat_bit (pat_bit)
    );

    // Registered redundancy mode and change detection
    assign mode_chg = (tmr_en != (mode_q == MODE_TRIPLE));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= tmr_en ? MODE_TRIPLE : MODE_SINGLE;
        end else begin
            mode_q <= tmr_en ? MODE_TRIPLE : MODE_SINGLE;
        end
    end

    // Value copy 0 takes at the coming edge, used to realign the others
    assign lead_next = {q[0][CHAIN_LEN-2:0], pat_bit} ^ flip[0];

    for (genvar c = 0; c < NCOPY; c++) begin : g_copy
        assign flip[c] = (inj_stb && (inj_copy == COPY_W'(c))) ? (ONE_BIT << inj_pos)
                                                              : '0;
        tsr_chain #(
            .LEN (CHAIN_LEN)
        ) u_chain (
            .clk    (clk),
            .rst    (rst),
            .din    (pat_bit),
            .resync ((c != 0) ? mode_chg : 1'b0),
            .load   (lead_next),
            .flip   (flip[c]),
            .q      (q[c])
        );
    end

    assign tails = '{t2: q[2][CHAIN_LEN-1], t1: q[1][CHAIN_LEN-1], t0: q[0][CHAIN_LEN-1]};

    tsr_voter u_vote (
        .tails (tails),
        .mode  (mode_q),
        .y     (data_out)
    );

    tsr_checker #(
        .CHAIN_LEN (CHAIN_LEN),
        .PAT_LEN   (PAT_LEN),
        .PAT_BITS  (PAT_BITS),
        .CNT_W     (CNT_W)
    ) u_chk (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .observed   (data_out),
        .mode_chg   (mode_chg),
        .fail_flag  (fail_flag),
        .fail_count (fail_count)
    );

    // R8: after a mode switch with no injection, all copies agree
    a_r8_resync: assert property (@(posedge clk) disable iff (rst)
        (mode_chg && !inj_stb) |=> ((q[1] == q[0]) && (q[2] == q[0])));

    // R4: in triple mode, two agreeing minority copies set the output
    a_r4_vote: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == MODE_TRIPLE) && (tails.t1 == tails.t2)) |-> (data_out == tails.t1));

    // R3: in single mode, the other copies do not steer the output
    a_r3_single: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SINGLE) |-> (data_out == q[0][CHAIN_LEN-1]));

    // R1: outputs clear after reset
    a_r1_out_clear: assert property (@(posedge clk)
        rst |=> (!data_out && !fail_flag && (fail_count == '0)));

endmodule

// File: tb/tsr_top_tb.sv
`timescale 1ns/1ps
module tsr_top_tb;

    localparam int          N      = 32;
    localparam logic [3:0]  PAT    = 4'b1101;
    localparam int          CW     = 8;
    localparam int          NV     = 8;

    // Vector fields: {tmr_en, copy[1:0], pos[4:0], expected failure increment}
    localparam logic [8:0] VEC [NV] = '{
        {1'b0, 2'd0, 5'd0,  1'b1},
        {1'b0, 2'd0, 5'd31, 1'b1},
        {1'b0, 2'd1, 5'd5,  1'b0},
        {1'b0, 2'd2, 5'd17, 1'b0},
        {1'b1, 2'd0, 5'd10, 1'b0},
        {1'b1, 2'd1, 5'd31, 1'b0},
        {1'b1, 2'd2, 5'd0,  1'b0},
        {1'b1, 2'd3, 5'd3,  1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tmr_en = 1'b0;
    logic          inj_stb = 1'b0;
    logic [1:0]    inj_copy = '0;
    logic [4:0]    inj_pos = '0;
    logic          data_out;
    logic          fail_flag;
    logic [CW-1:0] fail_count;

    int total = 0;
    int bad = 0;
    int j = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) j <= 0;
        else     j <= j + 1;
    end

    tsr_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .tmr_en     (tmr_en),
        .inj_stb    (inj_stb),
        .inj_copy   (inj_copy),
        .inj_pos    (inj_pos),
        .data_out   (data_out),
        .fail_flag  (fail_flag),
        .fail_count (fail_count)
    );

    function automatic logic model_bit(input int edges);
        if (edges < N) return 1'b0;
        return PAT[3 - ((edges - N) % 4)];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, j);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        if (tmr_en != m) begin
            tmr_en = m;
            wait_cyc(2 * N);
        end
    endtask

    task automatic inject(input logic [1:0] cp, input logic [4:0] ps);
        @(negedge clk);
        inj_stb = 1'b1; inj_copy = cp; inj_pos = ps;
        @(negedge clk);
        inj_stb = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c0;
        // Reset state (R1)
        repeat (3) @(negedge clk);
        chk(data_out == 1'b0, "R1 data_out in reset", data_out, 0);
        chk(fail_flag == 1'b0, "R1 fail_flag in reset", fail_flag, 0);
        chk(fail_count == '0, "R1 fail_count in reset", fail_count, 0);
        rst = 1'b0;

        // Early output stays zero, then the pattern follows (R2)
        wait_cyc(5);
        chk(data_out == 1'b0, "R2 early output zero", data_out, 0);
        wait_cyc(N + 4);
        for (int k = 0; k < 12; k++) begin
            chk(data_out == model_bit(j), "R2 pattern", data_out, model_bit(j));
            @(negedge clk);
        end
        chk(fail_flag == 1'b0, "R6 no failure on clean run", fail_flag, 0);

        // Vector table: single upsets with and without redundancy (R3/R4/R5)
        for (int v = 0; v < NV; v++) begin
            set_mode(VEC[v][8]);
            c0 = fail_count;
            inject(VEC[v][7:6], VEC[v][5:1]);
            wait_cyc(2 * N);
            chk(fail_count == CW'(c0 + int'(VEC[v][0])), $sformatf("R3/R4/R5 vector %0d", v),
                fail_count, c0 + int'(VEC[v][0]));
            chk(data_out == model_bit(j), $sformatf("R2 after vector %0d", v),
                data_out, model_bit(j));
        end

        // Exact timing of one upset and its count (R5, R6)
        set_mode(1'b0);
        @(negedge clk);
        c0 = fail_count;
        inj_stb = 1'b1; inj_copy = 2'd0; inj_pos = 5'd28;
        @(negedge clk);
        inj_stb = 1'b0;
        chk(data_out == model_bit(j), "R5 edge 0 clean", data_out, model_bit(j));
        wait_cyc(2);
        chk(data_out == model_bit(j), "R5 edge 2 clean", data_out, model_bit(j));
        @(negedge clk);
        chk(data_out == !model_bit(j), "R5 edge 3 flipped", data_out, !model_bit(j));
        chk(fail_count == CW'(c0), "R6 count not yet moved", fail_count, c0);
        @(negedge clk);
        chk(data_out == model_bit(j), "R5 edge 4 clean", data_out, model_bit(j));
        chk(fail_count == CW'(c0 + 1), "R6 count one edge later", fail_count, c0 + 1);
        chk(fail_flag == 1'b1, "R6 flag set", fail_flag, 1);

        // Two aligned upsets defeat the voter (R4)
        set_mode(1'b1);
        @(negedge clk);
        c0 = fail_count;
        inj_stb = 1'b1; inj_copy = 2'd0; inj_pos = 5'd20;
        @(negedge clk);
        inj_copy = 2'd1; inj_pos = 5'd21;
        @(negedge clk);
        inj_stb = 1'b0;
        wait_cyc(2 * N);
        chk(fail_count == CW'(c0 + 1), "R4 double upset counted", fail_count, c0 + 1);

        // Upset on the mode-switch edge is visible but masked (R8)
        @(negedge clk);
        c0 = fail_count;
        tmr_en = 1'b0;
        inj_stb = 1'b1; inj_copy = 2'd0; inj_pos = 5'd31;
        @(negedge clk);
        inj_stb = 1'b0;
        chk(data_out == !model_bit(j), "R8 upset reaches output", data_out, !model_bit(j));
        wait_cyc(2 * N);
        chk(fail_count == CW'(c0), "R8 masked after switch", fail_count, c0);

        // Forced mismatches saturate the counter (R7)
        @(negedge clk);
        inj_stb = 1'b1; inj_copy = 2'd0; inj_pos = 5'd31;
        wait_cyc(300);
        inj_stb = 1'b0;
        wait_cyc(2);
        chk(fail_count == 8'd255, "R7 saturation", fail_count, 255);
        wait_cyc(N);
        chk(fail_flag == 1'b1, "R7 flag held", fail_flag, 1);

        // Reset clears everything (R1)
        rst = 1'b1;
        wait_cyc(2);
        chk(fail_count == '0, "R1 count cleared", fail_count, 0);
        chk(fail_flag == 1'b0, "R1 flag cleared", fail_flag, 0);
        chk(data_out == 1'b0, "R1 output cleared", data_out, 0);
        rst = 1'b0;
        wait_cyc(N + 8);
        chk(data_out == model_bit(j), "R2 pattern after reset", data_out, model_bit(j));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule